// File: doc/BRIEF.md
# Strength-Reduced Complex LMS Equalizer

This block is an adaptive complex FIR equalizer with N taps whose weights are trained by the complex least-mean-squares rule. It keeps two transformed coefficient vectors: the sum c+d and the difference c-d of the real and imaginary weight parts. It also forms the difference of the real and imaginary input samples. With these, both the filter and the weight update need three real inner products per symbol instead of four. The real weight part c is rebuilt from the two stored vectors by a one-bit arithmetic shift. The step size is a power of two, so scaling an update is an arithmetic right shift by `mu_shift`.

One complex sample enters per symbol on a valid/ready stream. The slicer error that arrives with the same beat belongs to the output of the previous beat. Each accepted beat produces one complex output on a registered valid/ready stream. Parameters allow relaxed look-ahead pipelining. `ERR_DLY` delays the error feedback. `SUM_LEN` sums that many consecutive error products into each update. `COEF_DLY` hands the filter weights that are older by that many symbols. Back-pressure is simple: the output register holds one result, and a new sample is taken only while that register is empty or being drained in the same cycle.

Top module: `sreq_lms_equalizer`

## Requirements
- R1: A beat is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever `out_valid` is low or `out_ready` is high. `out_valid` is high in the cycle after an accepted beat and drops after an edge with `out_ready` high and no new beat.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid`, `yr_out` and `yi_out` hold their values and no input beat is accepted.
- R3: After reset, `out_valid` is low and the sample and error history is zero. The real weight of tap `CENTER` equals `INIT` and every other weight is zero. With zero errors, the output of beat k is therefore INIT·xr(k−CENTER) + j·INIT·xi(k−CENTER).
- R4: For beat k, the sample vector is X(k)[t] = x(k−t) for t in 0..N−1, and the weights are W = c + jd as they stood before beat k−COEF_DLY. The outputs are yr = Σ c·xr + d·xi and yi = Σ c·xi − d·xr, as full-precision signed `YW`-bit values. They appear, with `out_valid`, in the cycle after acceptance.
- R5: The error given with beat k pairs with X(k−1). At beat k each tap t adds 2^−s·Σi [er(k−ERR_DLY−i)·xr(m−t) + ei·xi(m−t)] to c and 2^−s·Σi [er·xi(m−t) − ei·xr(m−t)] to d, where i runs over 0..SUM_LEN−1 and m = k−1−ERR_DLY−i. The result matches a direct four-product cross-coupled update bit for bit whenever every error value is a multiple of 2^s.
- R6: Beats with zero error leave all weights unchanged.
- R7: The step is 2^−s, where s is the value on `mu_shift` in the cycle the beat is accepted.
- R8: Cycles without an accepted beat change neither weights nor history, whatever sits on the sample, error and `mu_shift` inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mu_shift | input | SW | Step-size exponent s, step = 2^−s |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take a beat this cycle |
| xr_in | input | XW | Real input sample, signed |
| xi_in | input | XW | Imaginary input sample, signed |
| er_in | input | EW | Real slicer error for the previous output, signed |
| ei_in | input | EW | Imaginary slicer error for the previous output, signed |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the output beat |
| yr_out | output | YW | Real filter output, signed |
| yi_out | output | YW | Imaginary filter output, signed |

## Verification
The assertions check the stream rules on every cycle. They confirm that `in_ready` follows the empty or draining output register, that a rising `out_valid` always has an accepted beat behind it, and that outputs hold under back-pressure. They also confirm that the centre weight never moves without an accepted beat and that the block leaves reset with an empty output. The arithmetic can only be shown by the bench's scenarios. These compare every output against a cross-coupled four-product reference with its own weight history, error delay and look-ahead sum, run with pipelining parameters above zero, several step sizes, idle gaps carrying junk inputs, and a held back-pressure stall.

// File: rtl/sreq_pkg.sv
package sreq_pkg;

  // Width needed to add up `terms` signed values of `term_w` bits each.
  function automatic int sum_width(input int term_w, input int terms);
    return term_w + $clog2(terms + 1);
  endfunction

  // Width of a signed product of two signed operands.
  function automatic int prod_width(input int a_w, input int b_w);
    return a_w + b_w;
  endfunction

endpackage

// File: rtl/sreq_tapline.sv
// Sample delay line and error history, both advanced once per accepted symbol.
module sreq_tapline #(
  parameter int L  = 8,
  parameter int EH = 1,
  parameter int XW = 10,
  parameter int EW = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 adv,
  input  logic signed [XW-1:0] xr_in,
  input  logic signed [XW-1:0] xi_in,
  input  logic signed [EW-1:0] er_in,
  input  logic signed [EW-1:0] ei_in,
  output logic signed [XW-1:0] xr_q [L],
  output logic signed [XW-1:0] xi_q [L],
  output logic signed [EW-1:0] er_h [EH],
  output logic signed [EW-1:0] ei_h [EH]
);

  // xr_q[j] holds the sample of the beat j+1 symbols back.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < L; j++) begin
        xr_q[j] <= '0;
        xi_q[j] <= '0;
      end
    end else if (adv) begin
      xr_q[0] <= xr_in;
      xi_q[0] <= xi_in;
      for (int j = 1; j < L; j++) begin
        xr_q[j] <= xr_q[j-1];
        xi_q[j] <= xi_q[j-1];
      end
    end
  end

  // er_h[0] is the error presented with the current beat, er_h[j] is j beats older.
  assign er_h[0] = er_in;
  assign ei_h[0] = ei_in;

  generate
    if (EH > 1) begin : g_err_hist
      logic signed [EW-1:0] er_r [EH-1];
      logic signed [EW-1:0] ei_r [EH-1];

      always_ff @(posedge clk) begin
        if (rst) begin
          for (int j = 0; j < EH-1; j++) begin
            er_r[j] <= '0;
            ei_r[j] <= '0;
          end
        end else if (adv) begin
          er_r[0] <= er_in;
          ei_r[0] <= ei_in;
          for (int j = 1; j < EH-1; j++) begin
            er_r[j] <= er_r[j-1];
            ei_r[j] <= ei_r[j-1];
          end
        end
      end

      for (genvar j = 1; j < EH; j++) begin : g_tap
        assign er_h[j] = er_r[j-1];
        assign ei_h[j] = ei_r[j-1];
      end
    end
  endgenerate

endmodule

// File: rtl/sreq_filter.sv
// Three real inner products over the transformed weights give the complex output.
module sreq_filter #(
  parameter int N  = 8,
  parameter int XW = 10,
  parameter int CW = 24,
  parameter int YW = 40
) (
  input  logic signed [XW-1:0] xr_v [N],
  input  logic signed [XW-1:0] xi_v [N],
  input  logic signed [CW-1:0] c1_w [N],
  input  logic signed [CW-1:0] d1_w [N],
  output logic signed [YW-1:0] yr,
  output logic signed [YW-1:0] yi
);

  localparam int PW = sreq_pkg::prod_width(CW + 1, XW + 1);

  logic signed [CW:0]   wsum [N];
  logic signed [CW-1:0] c_t  [N];
  logic signed [XW:0]   xd_t [N];
  logic signed [PW-1:0] p_c  [N];
  logic signed [PW-1:0] p_s  [N];
  logic signed [PW-1:0] p_d  [N];

  always_comb begin
    yr = '0;
    yi = '0;
    for (int t = 0; t < N; t++) begin
      // (c+d)+(c-d) is always even, so the shift recovers c exactly.
      wsum[t] = (CW+1)'(c1_w[t]) + (CW+1)'(d1_w[t]);
      c_t[t]  = CW'(wsum[t] >>> 1);
      xd_t[t] = (XW+1)'(xr_v[t]) - (XW+1)'(xi_v[t]);
      p_c[t]  = PW'(c_t[t])  * PW'(xd_t[t]);
      p_s[t]  = PW'(c1_w[t]) * PW'(xi_v[t]);
      p_d[t]  = PW'(d1_w[t]) * PW'(xr_v[t]);
      yr = yr + YW'(p_c[t]) + YW'(p_s[t]);
      yi = yi + YW'(p_d[t]) - YW'(p_c[t]);
    end
  end

endmodule

// File: rtl/sreq_wupdate.sv
// Weight update in the transformed domain, with relaxed look-ahead and weight delay.
module sreq_wupdate #(
  parameter int N      = 8,
  parameter int L      = 8,
  parameter int EH     = 1,
  parameter int XW     = 10,
  parameter int EW     = 10,
  parameter int CW     = 24,
  parameter int SW     = 3,
  parameter int D1     = 0,
  parameter int D2     = 0,
  parameter int LA     = 1,
  parameter int CENTER = 4,
  parameter int INIT   = 256
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 adv,
  input  logic [SW-1:0]        mu_shift,
  input  logic signed [XW-1:0] xr_q [L],
  input  logic signed [XW-1:0] xi_q [L],
  input  logic signed [EW-1:0] er_h [EH],
  input  logic signed [EW-1:0] ei_h [EH],
  output logic signed [CW-1:0] c1_cur [N],
  output logic signed [CW-1:0] d1_cur [N],
  output logic signed [CW-1:0] c1_use [N],
  output logic signed [CW-1:0] d1_use [N]
);

  localparam int PE = sreq_pkg::prod_width(EW + 1, XW + 1) + 1;
  localparam int UW = sreq_pkg::sum_width(PE + 1, LA);

  function automatic logic signed [CW-1:0] init_of(input int t);
    return (t == CENTER) ? CW'(INIT) : '0;
  endfunction

  logic signed [CW-1:0] c1_q  [N];
  logic signed [CW-1:0] d1_q  [N];
  logic signed [UW-1:0] acc_a [N];
  logic signed [UW-1:0] acc_b [N];
  logic signed [CW-1:0] c1_nx [N];
  logic signed [CW-1:0] d1_nx [N];

  always_comb begin
    for (int t = 0; t < N; t++) begin
      acc_a[t] = '0;
      acc_b[t] = '0;
      for (int i = 0; i < LA; i++) begin
        logic signed [EW:0]   e_d;
        logic signed [XW:0]   x_d;
        logic signed [PE-1:0] ex_r;
        logic signed [PE-1:0] ex_i;
        logic signed [PE-1:0] ex_d;
        // Error of beat k-D1-i meets the sample vector of beat k-1-D1-i.
        e_d  = (EW+1)'(er_h[D1+i]) - (EW+1)'(ei_h[D1+i]);
        x_d  = (XW+1)'(xr_q[D1+i+t]) - (XW+1)'(xi_q[D1+i+t]);
        ex_r = (PE'(er_h[D1+i]) * PE'(xi_q[D1+i+t])) <<< 1;
        ex_i = (PE'(ei_h[D1+i]) * PE'(xr_q[D1+i+t])) <<< 1;
        ex_d = PE'(e_d) * PE'(x_d);
        acc_a[t] = acc_a[t] + UW'(ex_r) + UW'(ex_d);
        acc_b[t] = acc_b[t] + UW'(ex_i) + UW'(ex_d);
      end
      c1_nx[t] = c1_q[t] + CW'(acc_a[t] >>> mu_shift);
      d1_nx[t] = d1_q[t] + CW'(acc_b[t] >>> mu_shift);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int t = 0; t < N; t++) begin
        c1_q[t] <= init_of(t);
        d1_q[t] <= init_of(t);
      end
    end else if (adv) begin
      for (int t = 0; t < N; t++) begin
        c1_q[t] <= c1_nx[t];
        d1_q[t] <= d1_nx[t];
      end
    end
  end

  assign c1_cur = c1_q;
  assign d1_cur = d1_q;

  generate
    if (D2 == 0) begin : g_no_wdly
      assign c1_use = c1_q;
      assign d1_use = d1_q;
    end else begin : g_wdly
      logic signed [CW-1:0] c1_s [D2][N];
      logic signed [CW-1:0] d1_s [D2][N];

      always_ff @(posedge clk) begin
        if (rst) begin
          for (int s = 0; s < D2; s++) begin
            for (int t = 0; t < N; t++) begin
              c1_s[s][t] <= init_of(t);
              d1_s[s][t] <= init_of(t);
            end
          end
        end else if (adv) begin
          c1_s[0] <= c1_q;
          d1_s[0] <= d1_q;
          for (int s = 1; s < D2; s++) begin
            c1_s[s] <= c1_s[s-1];
            d1_s[s] <= d1_s[s-1];
          end
        end
      end

      assign c1_use = c1_s[D2-1];
      assign d1_use = d1_s[D2-1];
    end
  endgenerate

endmodule

// File: rtl/sreq_lms_equalizer.sv
// Top: stream handshake, sample line, transformed filter and weight update.
module sreq_lms_equalizer #(
  parameter int N      = 8,
  parameter int XW     = 10,
  parameter int EW     = 10,
  parameter int CW     = 24,
  parameter int SW     = 3,
  parameter int D1     = 0,
  parameter int D2     = 0,
  parameter int LA     = 1,
  parameter int CENTER = N / 2,
  parameter int INIT   = 256,
  localparam int YW    = XW + CW + 2 + $clog2(N) + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [SW-1:0]        mu_shift,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [XW-1:0] xr_in,
  input  logic signed [XW-1:0] xi_in,
  input  logic signed [EW-1:0] er_in,
  input  logic signed [EW-1:0] ei_in,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [YW-1:0] yr_out,
  output logic signed [YW-1:0] yi_out
);

  localparam int L  = N + D1 + LA - 1;
  localparam int EH = D1 + LA;

  logic fire;
  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  logic signed [XW-1:0] xr_q [L];
  logic signed [XW-1:0] xi_q [L];
  logic signed [EW-1:0] er_h [EH];
  logic signed [EW-1:0] ei_h [EH];

  sreq_tapline #(.L(L), .EH(EH), .XW(XW), .EW(EW)) u_line (
    .clk(clk), .rst(rst), .adv(fire),
    .xr_in(xr_in), .xi_in(xi_in), .er_in(er_in), .ei_in(ei_in),
    .xr_q(xr_q), .xi_q(xi_q), .er_h(er_h), .ei_h(ei_h)
  );

  // Sample vector of the beat being accepted: newest sample at tap 0.
  logic signed [XW-1:0] xr_v [N];
  logic signed [XW-1:0] xi_v [N];
  assign xr_v[0] = xr_in;
  assign xi_v[0] = xi_in;
  generate
    for (genvar t = 1; t < N; t++) begin : g_vec
      assign xr_v[t] = xr_q[t-1];
      assign xi_v[t] = xi_q[t-1];
    end
  endgenerate

  logic signed [CW-1:0] c1_cur [N];
  logic signed [CW-1:0] d1_cur [N];
  logic signed [CW-1:0] c1_use [N];
  logic signed [CW-1:0] d1_use [N];

  sreq_wupdate #(
    .N(N), .L(L), .EH(EH), .XW(XW), .EW(EW), .CW(CW), .SW(SW),
    .D1(D1), .D2(D2), .LA(LA), .CENTER(CENTER), .INIT(INIT)
  ) u_wud (
    .clk(clk), .rst(rst), .adv(fire), .mu_shift(mu_shift),
    .xr_q(xr_q), .xi_q(xi_q), .er_h(er_h), .ei_h(ei_h),
    .c1_cur(c1_cur), .d1_cur(d1_cur), .c1_use(c1_use), .d1_use(d1_use)
  );

  logic signed [YW-1:0] yr_c;
  logic signed [YW-1:0] yi_c;

  sreq_filter #(.N(N), .XW(XW), .CW(CW), .YW(YW)) u_fir (
    .xr_v(xr_v), .xi_v(xi_v), .c1_w(c1_use), .d1_w(d1_use),
    .yr(yr_c), .yi(yi_c)
  );

  // Centre weight, watched by the bound checker.
  logic signed [CW-1:0] c1_mon;
  assign c1_mon = c1_cur[CENTER] + d1_cur[CENTER];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      yr_out    <= '0;
      yi_out    <= '0;
    end else if (fire) begin
      out_valid <= 1'b1;
      yr_out    <= yr_c;
      yi_out    <= yi_c;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/sreq_lms_chk.sv
// Protocol and state checks, bound into the equalizer top.
module sreq_lms_chk #(
  parameter int YW = 40,
  parameter int CW = 24
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic signed [YW-1:0] yr_out,
  input logic signed [YW-1:0] yi_out,
  input logic signed [CW-1:0] c1_mon
);

  // R1: an empty output register always accepts.
  assert_ready_when_empty_R1: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

  // R1: a new output beat only follows an accepted input beat.
  assert_valid_source_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  // R2: a stalled output holds still.
  assert_hold_under_stall_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(yr_out) && $stable(yi_out)));

  // R3: the block leaves reset with an empty output.
  assert_reset_empty_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !out_valid);

  // R8: weights move only on accepted beats.
  assert_weight_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> $stable(c1_mon));

endmodule

bind sreq_lms_equalizer sreq_lms_chk #(.YW(YW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready),
  .yr_out(yr_out), .yi_out(yi_out), .c1_mon(c1_mon)
);

// File: tb/test_sreq_lms_equalizer.sv
module test_sreq_lms_equalizer;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int N = 8, XW = 10, EW = 10, CW = 24, SW = 3;
  localparam int D1 = 1, D2 = 1, LA = 2, CENTER = 3, INIT = 256;
  localparam int YW = XW + CW + 2 + $clog2(N) + 1;
  localparam int HL = N + D1 + LA + 1;
  localparam int EHB = D1 + LA;
  localparam real CLKP = 20.0;

  // Columns: xr, xi, er, ei, mu_shift. Errors are multiples of 32.
  localparam int NV = 20;
  localparam int VEC [NV][5] = '{
    '{ 17,  -5,  32,   0, 3}, '{-23,  40, -32,  32, 3},
    '{  8,  12,  64, -32, 4}, '{ 45, -50,   0,  96, 3},
    '{-12, -31, -64, -64, 5}, '{  3,  27,  32,  64, 4},
    '{ 50,  50, -96,   0, 3}, '{-50, -50,   0,   0, 3},
    '{ 19,  -7,  32, -96, 5}, '{ -4,  22, -32,  32, 4},
    '{ 36,  11,  64,   0, 3}, '{-28,   9,   0, -32, 3},
    '{  7, -44,  96,  32, 5}, '{  0,   0, -64,  64, 4},
    '{ 13,  33,  32,  32, 3}, '{-41,   2, -32, -96, 4},
    '{ 25, -18,   0,  64, 5}, '{ -9,  -9,  64, -64, 3},
    '{ 31,   6, -96,  32, 4}, '{-16,  48,  32,   0, 3}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [SW-1:0] mu_shift = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [XW-1:0] xr_in = '0;
  logic signed [XW-1:0] xi_in = '0;
  logic signed [EW-1:0] er_in = '0;
  logic signed [EW-1:0] ei_in = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic signed [YW-1:0] yr_out;
  logic signed [YW-1:0] yi_out;

  always #(CLKP/2) clk = ~clk;

  sreq_lms_equalizer #(
    .N(N), .XW(XW), .EW(EW), .CW(CW), .SW(SW),
    .D1(D1), .D2(D2), .LA(LA), .CENTER(CENTER), .INIT(INIT)
  ) i_sreq_lms_equalizer (
    .clk(clk), .rst(rst), .mu_shift(mu_shift),
    .in_valid(in_valid), .in_ready(in_ready),
    .xr_in(xr_in), .xi_in(xi_in), .er_in(er_in), .ei_in(ei_in),
    .out_valid(out_valid), .out_ready(out_ready),
    .yr_out(yr_out), .yi_out(yi_out)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Cross-coupled reference: direct weights c, d with COEF_DLY history.
  longint wc [D2+1][N];
  longint wd [D2+1][N];
  longint hxr [HL];
  longint hxi [HL];
  longint her [EHB];
  longint hei [EHB];

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s <= D2; s++)
      for (int t = 0; t < N; t++) begin
        wc[s][t] = (t == CENTER) ? INIT : 0;
        wd[s][t] = 0;
      end
    for (int j = 0; j < HL; j++) begin hxr[j] = 0; hxi[j] = 0; end
    for (int j = 0; j < EHB; j++) begin her[j] = 0; hei[j] = 0; end
  endtask

  task automatic model_beat(input int xr, input int xi, input int er, input int ei,
                            input int s, output longint eyr, output longint eyi);
    longint nc [N];
    longint nd [N];
    for (int j = HL-1; j > 0; j--) begin hxr[j] = hxr[j-1]; hxi[j] = hxi[j-1]; end
    hxr[0] = xr; hxi[0] = xi;
    for (int j = EHB-1; j > 0; j--) begin her[j] = her[j-1]; hei[j] = hei[j-1]; end
    her[0] = er; hei[0] = ei;
    eyr = 0; eyi = 0;
    for (int t = 0; t < N; t++) begin
      eyr += wc[D2][t] * hxr[t] + wd[D2][t] * hxi[t];
      eyi += wc[D2][t] * hxi[t] - wd[D2][t] * hxr[t];
    end
    for (int t = 0; t < N; t++) begin
      longint dc = 0;
      longint dd = 0;
      for (int i = 0; i < LA; i++) begin
        longint a = her[D1+i];
        longint b = hei[D1+i];
        longint p = hxr[1+D1+i+t];
        longint q = hxi[1+D1+i+t];
        dc += a * p + b * q;
        dd += a * q - b * p;
      end
      nc[t] = wc[0][t] + (dc >>> s);
      nd[t] = wd[0][t] + (dd >>> s);
    end
    for (int k = D2; k > 0; k--) begin wc[k] = wc[k-1]; wd[k] = wd[k-1]; end
    for (int t = 0; t < N; t++) begin wc[0][t] = nc[t]; wd[0][t] = nd[t]; end
  endtask

  // One accepted beat with the consumer ready; outputs checked after the edge.
  task automatic send(input string req, input int xr, input int xi, input int er,
                      input int ei, input int s, output longint ayr, output longint ayi);
    longint eyr, eyi;
    @(negedge clk);
    xr_in = XW'(xr); xi_in = XW'(xi); er_in = EW'(er); ei_in = EW'(ei);
    mu_shift = SW'(s); in_valid = 1'b1; out_ready = 1'b1;
    model_beat(xr, xi, er, ei, s, eyr, eyi);
    @(negedge clk);
    in_valid = 1'b0;
    ayr = longint'(yr_out);
    ayi = longint'(yi_out);
    check(req, "out_valid", longint'(out_valid), 1);
    check(req, "yr", ayr, eyr);
    check(req, "yi", ayi, eyi);
  endtask

  initial begin
    longint ayr, ayi, ryr, ryi, byr, byi;
    int xa [6];
    int xb [6];
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R3: empty after reset; R1: ready while empty.
    check("R3", "out_valid after reset", longint'(out_valid), 0);
    check("R1", "in_ready while empty", longint'(in_ready), 1);

    // R3 and R6: zero errors keep the preloaded centre tap, output is a pure delay.
    for (int k = 0; k < 6; k++) begin
      xa[k] = (k + 1) * 7;
      xb[k] = -(k * 4 + 3);
      send("R6", xa[k], xb[k], 0, 0, 3, ayr, ayi);
      check("R3", "delay yr", ayr, (k >= CENTER) ? longint'(INIT) * xa[k-CENTER] : 0);
      check("R3", "delay yi", ayi, (k >= CENTER) ? longint'(INIT) * xb[k-CENTER] : 0);
    end

    // R4, R5, R7: adaptation with look-ahead, error delay and varying step.
    for (int v = 0; v < NV; v++)
      send("R4 R5 R7", VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], ayr, ayi);

    // R8: idle cycles with junk on every data input change nothing.
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      in_valid = 1'b0;
      xr_in = XW'(100 + c); xi_in = XW'(-90 - c);
      er_in = EW'(200 - 32 * c); ei_in = EW'(-150);
      mu_shift = SW'(c);
      if (c > 0) check("R1", "out_valid idle", longint'(out_valid), 0);
    end
    send("R8", 11, -13, 32, -32, 3, ayr, ayi);

    // R2: stall with a second beat waiting.
    @(negedge clk);
    out_ready = 1'b0;
    xr_in = XW'(21); xi_in = XW'(-6); er_in = EW'(64); ei_in = EW'(32);
    mu_shift = SW'(4); in_valid = 1'b1;
    model_beat(21, -6, 64, 32, 4, ryr, ryi);
    @(negedge clk);
    xr_in = XW'(-37); xi_in = XW'(15); er_in = EW'(-32); ei_in = EW'(96);
    mu_shift = SW'(3);
    for (int c = 0; c < 4; c++) begin
      check("R2", "in_ready stalled", longint'(in_ready), 0);
      check("R2", "out_valid stalled", longint'(out_valid), 1);
      check("R2", "yr held", longint'(yr_out), ryr);
      check("R2", "yi held", longint'(yi_out), ryi);
      @(negedge clk);
    end
    model_beat(-37, 15, -32, 96, 3, byr, byi);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2", "yr after release", longint'(yr_out), byr);
    check("R2", "yi after release", longint'(yi_out), byi);
    send("R5", 5, 9, -64, 32, 3, ayr, ayi);

    @(negedge clk);
    check("R1", "out_valid drained", longint'(out_valid), 0);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLKP * 200000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1 actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule